// File: doc/BRIEF.md
# Opcode-Indexed Microprogram Sequencer

This block steps through a 512-word microprogram store and hands each microinstruction's control bits to the datapath. Every instruction starts with one fetch/decode microinstruction. When that word is current, the incoming 8-bit opcode becomes the next microaddress directly, with no mapping stage. The first execute step of every opcode therefore sits in the lower half of the store, at an address equal to the opcode. From there, each word's next-address field moves execution into the upper half. A word may instead branch on one of four condition flags. There is no microsubroutine stack.

Interrupt requests are sampled only at the fetch word, which is the instruction boundary. A fault strobe takes effect at once: it drops the result-write enable in the same cycle and sends the sequencer to the fault routine on the next clock edge. A fault outranks an interrupt. The store is a read-only array that is filled when the design is initialised. It is read synchronously, so the microaddress and the control outputs are both registered and always belong together.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high, `uaddr` is 0x100 (the fetch word), `is_fetch` is 1 and `wr_en` is 0. After reset, execution starts at 0x100.
- R2: When the current word is the fetch word and neither `fault` nor `irq` is high, the next `uaddr` equals {1'b0, `opcode`}.
- R3: When the current word is not the fetch word, is not branching, and `fault` is low, the next `uaddr` is 0x100 plus the word's 8-bit next field.
- R4: When a non-fetch word has its branch bit set and `fault` is low, the next `uaddr` is 0x100 plus its 8-bit target if `flags[csel]` is 1. Otherwise it is 0x100 plus its next field.
- R5: At the fetch word, `irq` high with `fault` low makes the next `uaddr` 0x1FE. At any other word, `irq` has no effect on the next address.
- R6: With `fault` high, the next `uaddr` is 0x1FF whatever the current word, `irq`, `opcode` or `flags` are, and `wr_en` is 0 in that same cycle.
- R7: `wr_en` equals the current word's write bit whenever `fault` and `rst` are low.
- R8: `uaddr`, `ctrl` and `is_fetch` are registered and always describe the same store word.
- R9: The store contents follow these rules, where `lo` is the low 8 bits of the address:
  - Lower word `lo`: write=1, ctrl=`lo`, branch=`lo[7]`, csel=`lo[1:0]`, target=0x80|`lo[6:0]`, next=1+`lo[1:0]`.
  - Word 0x100: fetch=1, write=0, ctrl=0, next=0.
  - Word 0x1FF: write=0, ctrl=0xFF, next=0.
  - Word 0x1FE: write=1, ctrl=0xFE, next=0.
  - Other upper words: write=1, ctrl=`lo`, no branch, next=`lo`+1 if `lo`<4, else 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Opcode of the instruction being fetched |
| flags | input | 4 | Condition flags used by branching words |
| irq | input | 1 | Interrupt request, level |
| fault | input | 1 | Fault strobe |
| uaddr | output | 9 | Address of the current microinstruction |
| ctrl | output | 8 | Control field of the current microinstruction |
| is_fetch | output | 1 | Current word is the fetch microinstruction |
| wr_en | output | 1 | Result-write enable, blocked during a fault |

## Verification
The hardest case to reach from the ports is a fault that lands on the fetch word in the same cycle as an interrupt request and a fresh opcode. In that cycle, all three higher-priority paths compete for the next address. The bench follows its own model of the microaddress. In a late phase it raises `fault` and `irq` together exactly when the model says the fetch word is current, and it also raises `irq` freely during execute words. This exercises both the priority order and the rule that an interrupt is ignored away from the instruction boundary.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int AW       = 9;
  localparam int OPW      = AW - 1;
  localparam int CTRL_W   = 8;
  localparam int COND_W   = 4;
  localparam int CSEL_W   = $clog2(COND_W);
  localparam int DEPTH    = 1 << AW;
  localparam int CHAIN_END = 4;

  localparam logic [AW-1:0] FETCH_ADDR = AW'(1 << OPW);
  localparam logic [AW-1:0] FAULT_VEC  = '1;
  localparam logic [AW-1:0] IRQ_VEC    = FAULT_VEC - AW'(1);

  typedef struct packed {
    logic              fetch;
    logic              wr;
    logic              br;
    logic [CSEL_W-1:0] csel;
    logic [OPW-1:0]    tgt;
    logic [OPW-1:0]    nxt;
    logic [CTRL_W-1:0] ctrl;
  } uword_t;

  localparam int UW = $bits(uword_t);

  // Generated microprogram; all offsets are relative to the upper half.
  function automatic uword_t seed_word(input logic [AW-1:0] a);
    uword_t w;
    logic [OPW-1:0] lo;
    w  = '0;
    lo = a[OPW-1:0];
    w.ctrl = CTRL_W'(lo);
    if (!a[AW-1]) begin
      w.wr   = 1'b1;
      w.br   = lo[OPW-1];
      w.csel = lo[CSEL_W-1:0];
      w.tgt  = {1'b1, lo[OPW-2:0]};
      w.nxt  = OPW'(1) + OPW'(lo[1:0]);
    end else if (a == FETCH_ADDR) begin
      w.fetch = 1'b1;
    end else if (a == FAULT_VEC) begin
      w.nxt = '0;
    end else if (a == IRQ_VEC) begin
      w.wr  = 1'b1;
      w.nxt = '0;
    end else begin
      w.wr  = 1'b1;
      w.nxt = (int'(lo) < CHAIN_END) ? lo + OPW'(1) : '0;
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output uword_t            rdata
);
  localparam int NWORDS = 1 << ADDR_W;

  uword_t mem [NWORDS];

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = seed_word(AW'(i));
  end

  always_ff @(posedge clk) rdata <= mem[raddr];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  uword_t            cur,
  input  logic [OPW-1:0]    opcode,
  input  logic [COND_W-1:0] flags,
  input  logic              irq,
  input  logic              fault,
  output logic [AW-1:0]     nxt_addr
);
  logic cond_hit;

  always_comb begin
    cond_hit = flags[cur.csel];
    if (fault)                   nxt_addr = FAULT_VEC;
    else if (cur.fetch && irq)   nxt_addr = IRQ_VEC;
    else if (cur.fetch)          nxt_addr = {1'b0, opcode};
    else if (cur.br && cond_hit) nxt_addr = {1'b1, cur.tgt};
    else                         nxt_addr = {1'b1, cur.nxt};
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        opcode,
  input  logic [3:0]        flags,
  input  logic              irq,
  input  logic              fault,
  output logic [8:0]        uaddr,
  output logic [7:0]        ctrl,
  output logic              is_fetch,
  output logic              wr_en
);
  uword_t        word;
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] raddr;
  logic [AW-1:0] uaddr_q;

  useq_next u_next (
    .cur      (word),
    .opcode   (opcode),
    .flags    (flags),
    .irq      (irq),
    .fault    (fault),
    .nxt_addr (nxt_addr)
  );

  assign raddr = rst ? FETCH_ADDR : nxt_addr;

  useq_store #(.ADDR_W(AW)) u_store (
    .clk   (clk),
    .raddr (raddr),
    .rdata (word)
  );

  always_ff @(posedge clk) begin
    if (rst) uaddr_q <= FETCH_ADDR;
    else     uaddr_q <= nxt_addr;
  end

  assign uaddr    = uaddr_q;
  assign ctrl     = word.ctrl;
  assign is_fetch = word.fetch;
  assign wr_en    = word.wr & ~fault & ~rst;

  a_r2_opcode_start: assert property (@(posedge clk) disable iff (rst)
    (is_fetch && !fault && !irq) |=> (uaddr == {1'b0, $past(opcode)}));

  a_r5_irq_vector: assert property (@(posedge clk) disable iff (rst)
    (is_fetch && irq && !fault) |=> (uaddr == IRQ_VEC));

  a_r3_stay_upper: assert property (@(posedge clk) disable iff (rst)
    (!is_fetch && !fault) |=> uaddr[AW-1]);

  a_r6_fault_vector: assert property (@(posedge clk) disable iff (rst)
    fault |=> (uaddr == FAULT_VEC));

  a_r7_fetch_nowrite: assert property (@(posedge clk) disable iff (rst)
    is_fetch |-> !wr_en);
endmodule

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opcode = '0;
  logic [3:0] flags = '0;
  logic       irq = 1'b0;
  logic       fault = 1'b0;
  logic [8:0] uaddr;
  logic [7:0] ctrl;
  logic       is_fetch;
  logic       wr_en;

  int errors = 0;
  int checks = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  useq_top dut (
    .clk(clk), .rst(rst), .opcode(opcode), .flags(flags),
    .irq(irq), .fault(fault), .uaddr(uaddr), .ctrl(ctrl),
    .is_fetch(is_fetch), .wr_en(wr_en)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // Reference contents per R9: {fetch, wr, br, csel, tgt, nxt, ctrl}
  task automatic ref_word(input int a, output bit f, output bit w, output bit b,
                          output int cs, output int tg, output int nx, output int ct);
    int lo;
    lo = a % 256;
    f = 0; w = 0; b = 0; cs = 0; tg = 0; nx = 0; ct = lo;
    if (a < 256) begin
      w = 1; b = (lo >= 128); cs = lo % 4; tg = 128 + (lo % 128); nx = 1 + (lo % 4);
    end else if (a == 256) begin
      f = 1;
    end else if (a == 511) begin
      nx = 0;
    end else if (a == 510) begin
      w = 1;
    end else begin
      w = 1; nx = (lo < 4) ? lo + 1 : 0;
    end
  endtask

  int m_addr;
  int m_nxt;
  string m_tag;
  bit done = 0;

  task automatic check_outputs();
    bit f, w, b; int cs, tg, nx, ct;
    ref_word(m_addr, f, w, b, cs, tg, nx, ct);
    chk(uaddr == 9'(m_addr), m_tag, uaddr, m_addr);
    chk(ctrl == 8'(ct), "R9 ctrl", ctrl, ct);
    chk(is_fetch == f, "R8 is_fetch", is_fetch, f);
    if (fault) chk(wr_en == 1'b0, "R6 wr_en", wr_en, 0);
    else       chk(wr_en == w, "R7 wr_en", wr_en, w);
  endtask

  task automatic step_model();
    bit f, w, b; int cs, tg, nx, ct;
    ref_word(m_addr, f, w, b, cs, tg, nx, ct);
    if (fault) begin m_nxt = 511; m_tag = "R6 uaddr"; end
    else if (f && irq) begin m_nxt = 510; m_tag = "R5 uaddr"; end
    else if (f) begin m_nxt = int'(opcode); m_tag = "R2 uaddr"; end
    else if (b) begin
      m_nxt = flags[cs] ? 256 + tg : 256 + nx; m_tag = "R4 uaddr";
    end else begin
      m_nxt = 256 + nx; m_tag = irq ? "R5 uaddr ignored" : "R3 uaddr";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(uaddr == 9'h100, "R1 uaddr", uaddr, 9'h100);
    chk(is_fetch == 1'b1, "R1 is_fetch", is_fetch, 1);
    chk(wr_en == 1'b0, "R1 wr_en", wr_en, 0);
    m_nxt = 256;
    m_tag = "R1 uaddr";
    for (int it = 0; it < 4000; it++) begin
      logic [31:0] r;
      int ph;
      bit f0, w0, b0; int cs0, tg0, nx0, ct0;
      if (it > 0) @(negedge clk);
      rst = 1'b0;
      m_addr = m_nxt;
      ref_word(m_addr, f0, w0, b0, cs0, tg0, nx0, ct0);
      ph = it / 1000;
      r = rnd();
      opcode = r[7:0];
      flags  = r[11:8];
      irq    = (ph == 1 || ph == 3) ? (r[15:12] < 4'd5) : 1'b0;
      fault  = (ph >= 2) ? (r[19:16] < 4'd2) : 1'b0;
      if (ph == 3 && f0 && (it % 3 == 0)) begin irq = 1'b1; fault = 1'b1; end
      #1;
      check_outputs();
      step_model();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule